// File: doc/BRIEF.md
# Flag Register and Bus Select Decoder

This block holds the four status flags produced by an arithmetic unit and decodes the control word that arbitrates a shared data bus. When the arithmetic unit requests it, the flags are captured on the falling clock edge. They then stay unchanged until the next such request or until reset. No other path can clear them.

A 6-bit control word carries two independent 3-bit select codes. The low field names the register that loads from the bus, and the high field names the register that drives the bus. Each field is decoded into eight one-hot, active-low strobes. Code 0 means "none", so no strobe is active for it. Every strobe has an active-high lamp copy for indicator displays. The flag register is itself one of the bus sources. When the drive field selects it, the flags appear in the low nibble of the bus output.

Top module: `flag_bus_ctl`

## Requirements
- R1: A non-zero load code k (ctrl_word[2:0]) drives load_sel_n[k] low and all other load_sel_n bits high.
- R2: Load code 0 leaves every load_sel_n bit high.
- R3: Drive code k (ctrl_word[5:3]) drives drive_sel_n[k] low when k is non-zero. Drive code 0 leaves every drive_sel_n bit high.
- R4: load_lamp is the bitwise inverse of load_sel_n, and drive_lamp is the bitwise inverse of drive_sel_n, at all times.
- R5: On a falling clock edge where flag_load is high, flags_q takes the value of alu_flags_in. On a falling edge where flag_load is low, flags_q keeps its value.
- R6: An active-low rst_n clears flags_q to 0 at once, without waiting for a clock edge. Reset is the only path that clears the flags.
- R7: bus_oe is high only when the drive code equals 5. bus_out then carries {4'b0000, flags_q}; otherwise bus_out is 0.
- R8: The flag bit order is bit 3 carry, bit 2 zero, bit 1 negative, bit 0 overflow, and this order is kept on the bus.
- R9: The control word has no effect on flag capture. A load code of 5 with flag_load low leaves flags_q unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags are captured on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 6 | [2:0] load select code, [5:3] drive select code |
| flag_load | input | 1 | Capture request from the arithmetic unit |
| alu_flags_in | input | 4 | {carry, zero, negative, overflow} from the arithmetic unit |
| load_sel_n | output | 8 | One-hot active-low load strobes |
| drive_sel_n | output | 8 | One-hot active-low drive strobes |
| load_lamp | output | 8 | Active-high lamp copy of the load strobes |
| drive_lamp | output | 8 | Active-high lamp copy of the drive strobes |
| flags_q | output | 4 | Held flags |
| bus_out | output | 8 | Flag read-back onto the shared bus |
| bus_oe | output | 1 | High while the flag register drives the bus |

## Verification
The bench builds the block with its default parameters: 3-bit select codes (eight lines per field), an 8-bit bus, 4 flags, source code 5 and two reset-release stages. With these values the bench can step through all 64 control words, so every strobe, lamp and code-0 case is exercised. The 8-bit bus leaves four upper bits that must read zero whenever the flags are driven. Mid-cycle resets and captures of single-bit flag patterns check the asynchronous clear and the bit order on the bus.

// File: rtl/flag_bus_pkg.sv
package flag_bus_pkg;
  // Flag bit positions within the held vector
  localparam int FLG_CARRY = 3;
  localparam int FLG_ZERO  = 2;
  localparam int FLG_NEG   = 1;
  localparam int FLG_OVF   = 0;
  localparam int FLAG_N    = 4;

  typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/flag_rst_sync.sv
// Asynchronous assertion, release aligned to the falling edge used by the flag store.
module flag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sel_decoder.sv
// N-to-2^N decoder with active-low one-hot strobes; code 0 selects nothing.
module sel_decoder #(
  parameter int CODE_W = 3,
  localparam int LINES = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code,
  output logic [LINES-1:0]  sel_n,
  output logic [LINES-1:0]  lamp
);
  genvar i;
  generate
    for (i = 0; i < LINES; i++) begin : g_line
      if (i == 0) begin : g_none
        assign sel_n[i] = 1'b1;
      end else begin : g_sel
        localparam logic [CODE_W-1:0] K = i[CODE_W-1:0];
        assign sel_n[i] = (code != K);
      end
    end
  endgenerate

  assign lamp = ~sel_n;
endmodule

// File: rtl/flag_store.sv
// Flag holding register, captured on the falling edge under an explicit enable.
module flag_store
  import flag_bus_pkg::*;
(
  input  logic      clk,
  input  logic      rst_sync_n,
  input  logic      cap_en,
  input  flag_vec_t flags_in,
  output flag_vec_t flags_q
);
  flag_vec_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (cap_en) flags_d = flags_in;
  end

  always_ff @(negedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) flags_q <= '0;
    else             flags_q <= flags_d;
  end
endmodule

// File: rtl/flag_bus_ctl.sv
module flag_bus_ctl
  import flag_bus_pkg::*;
#(
  parameter int CODE_W      = 3,
  parameter int BUS_W       = 8,
  parameter int SRC_CODE    = 5,
  parameter int SYNC_STAGES = 2,
  localparam int LINES      = 1 << CODE_W,
  localparam int CTRL_W     = 2 * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              flag_load,
  input  logic [FLAG_N-1:0] alu_flags_in,
  output logic [LINES-1:0]  load_sel_n,
  output logic [LINES-1:0]  drive_sel_n,
  output logic [LINES-1:0]  load_lamp,
  output logic [LINES-1:0]  drive_lamp,
  output logic [FLAG_N-1:0] flags_q,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_oe
);
  logic      rst_sync_n;
  flag_vec_t held;

  flag_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sel_decoder #(.CODE_W(CODE_W)) u_load_dec (
    .code(ctrl_word[CODE_W-1:0]), .sel_n(load_sel_n), .lamp(load_lamp)
  );

  sel_decoder #(.CODE_W(CODE_W)) u_drive_dec (
    .code(ctrl_word[CTRL_W-1:CODE_W]), .sel_n(drive_sel_n), .lamp(drive_lamp)
  );

  flag_store u_flags (
    .clk(clk), .rst_sync_n(rst_sync_n), .cap_en(flag_load),
    .flags_in(alu_flags_in), .flags_q(held)
  );

  // Bus read-back: the flag source follows its own drive strobe
  always_comb begin
    bus_oe  = !drive_sel_n[SRC_CODE];
    bus_out = '0;
    if (bus_oe) bus_out[FLAG_N-1:0] = held;
  end

  assign flags_q = held;
endmodule

// File: rtl/flag_bus_ctl_chk.sv
module flag_bus_ctl_chk #(
  parameter int LINES = 8,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic [5:0]       ctrl_word,
  input logic             flag_load,
  input logic [3:0]       alu_flags_in,
  input logic [LINES-1:0] load_sel_n,
  input logic [LINES-1:0] drive_sel_n,
  input logic [LINES-1:0] load_lamp,
  input logic [LINES-1:0] drive_lamp,
  input logic [3:0]       flags_q,
  input logic [BUS_W-1:0] bus_out,
  input logic             bus_oe
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~load_sel_n));
  p_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[2:0] == 3'd0) |-> (&load_sel_n));
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[5:3] == 3'd0) |-> ((&drive_sel_n) && !bus_oe));
  p_lamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_lamp == ~load_sel_n) && (drive_lamp == ~drive_sel_n));
  p_capture_r5: assert property (@(negedge clk) disable iff (!rst_sync_n)
    flag_load |=> (flags_q == $past(alu_flags_in)));
  p_hold_r9: assert property (@(negedge clk) disable iff (!rst_sync_n)
    !flag_load |=> $stable(flags_q));
  p_clear_r6: assert property (@(posedge clk)
    !rst_sync_n |-> (flags_q == 4'd0));
  p_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_out == {{(BUS_W-4){1'b0}}, flags_q}));
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_out == '0));
endmodule

bind flag_bus_ctl flag_bus_ctl_chk #(.LINES(LINES), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n), .ctrl_word(ctrl_word),
  .flag_load(flag_load), .alu_flags_in(alu_flags_in), .load_sel_n(load_sel_n),
  .drive_sel_n(drive_sel_n), .load_lamp(load_lamp), .drive_lamp(drive_lamp),
  .flags_q(flags_q), .bus_out(bus_out), .bus_oe(bus_oe)
);

// File: tb/flag_bus_ctl_tb_top.sv
`timescale 1ns/1ps
module flag_bus_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] ctrl_word;
  logic       flag_load;
  logic [3:0] alu_flags_in;
  logic [7:0] load_sel_n, drive_sel_n, load_lamp, drive_lamp, bus_out;
  logic [3:0] flags_q;
  logic       bus_oe;

  int checks = 0;
  int errors = 0;
  logic [3:0] model_flags = 4'd0;
  bit done = 0;

  typedef struct {
    logic [7:0] ld_n, dr_n, bus;
    logic [3:0] flags;
    logic       oe;
    string      ld_tag, fl_tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;   // 125 MHz

  flag_bus_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .flag_load(flag_load),
    .alu_flags_in(alu_flags_in), .load_sel_n(load_sel_n), .drive_sel_n(drive_sel_n),
    .load_lamp(load_lamp), .drive_lamp(drive_lamp), .flags_q(flags_q),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  function automatic logic [7:0] dec_n(input logic [2:0] c);
    return (c == 3'd0) ? 8'hFF : ~(8'h01 << c);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: applies one control cycle, pushes the expected result
  task automatic drive(input logic [5:0] cw, input logic ld, input logic [3:0] fin);
    exp_t e;
    @(posedge clk); #1;
    ctrl_word = cw; flag_load = ld; alu_flags_in = fin;
    if (ld) model_flags = fin;
    e.ld_n   = dec_n(cw[2:0]);
    e.dr_n   = dec_n(cw[5:3]);
    e.flags  = model_flags;
    e.oe     = (cw[5:3] == 3'd5);
    e.bus    = e.oe ? {4'b0000, model_flags} : 8'h00;
    e.ld_tag = (cw[2:0] == 3'd0) ? "R2 load none" : "R1 load strobe";
    e.fl_tag = ld ? "R5 capture" : "R9 hold";
    sb_q.push_back(e);
  endtask

  // Monitor: samples after the falling edge capture, before the next rise
  initial begin
    forever begin
      @(negedge clk); #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.ld_tag, load_sel_n, e.ld_n);
        check("R3 drive strobe", drive_sel_n, e.dr_n);
        check("R4 load lamp", load_lamp, ~load_sel_n);
        check("R4 drive lamp", drive_lamp, ~e.dr_n);
        check(e.fl_tag, {4'b0, flags_q}, {4'b0, e.flags});
        check("R7 bus_oe", {7'b0, bus_oe}, {7'b0, e.oe});
        check("R7 bus_out", bus_out, e.bus);
      end
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0; ctrl_word = '0; flag_load = 1'b0; alu_flags_in = '0;
    #1;
    check("R6 reset flags", {4'b0, flags_q}, 8'h00);
    idle(3);
    check("R6 reset bus", bus_out, 8'h00);
    #1 rst_n = 1'b1;
    idle(4);

    // Every control word with no capture: decoders, lamps, held zero flags
    for (int c = 0; c < 64; c++) drive(c[5:0], 1'b0, 4'hF);

    // R8: single carry flag lands on bus bit 3
    drive({3'd5, 3'd0}, 1'b1, 4'b1000);
    idle(1); #1;
    check("R8 carry on bus bit3", bus_out, 8'h08);
    drive({3'd5, 3'd0}, 1'b1, 4'b0001);
    idle(1); #1;
    check("R8 overflow on bus bit0", bus_out, 8'h01);

    // Captures with various patterns and selects
    drive({3'd5, 3'd3}, 1'b1, 4'hA);
    drive({3'd2, 3'd5}, 1'b0, 4'h5);   // R9: load code 5 without request
    drive({3'd5, 3'd5}, 1'b0, 4'h3);
    drive({3'd0, 3'd7}, 1'b1, 4'h6);
    drive({3'd5, 3'd1}, 1'b1, 4'h0);   // ALU-produced zeros are a capture
    drive({3'd5, 3'd0}, 1'b1, 4'hF);
    drive({3'd4, 3'd6}, 1'b0, 4'h2);
    drive({3'd5, 3'd5}, 1'b0, 4'h9);
    idle(2);

    // R6: reset asserted mid-cycle clears flags without a clock edge
    @(posedge clk); #2;
    flag_load = 1'b0; ctrl_word = {3'd5, 3'd0};
    rst_n = 1'b0; #1;
    check("R6 async clear", {4'b0, flags_q}, 8'h00);
    check("R6 clear on bus", bus_out, 8'h00);
    model_flags = 4'd0;
    idle(2); #1 rst_n = 1'b1;
    idle(4);
    drive({3'd5, 3'd0}, 1'b0, 4'hC);
    drive({3'd5, 3'd0}, 1'b1, 4'hC);
    drive({3'd5, 3'd0}, 1'b0, 4'h1);
    idle(3);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        idle(20000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule